// File: doc/BRIEF.md
# Buffered Auto-Reload Down Timer

This block is a down-counting timer whose period register is split in two: software writes land in a holding buffer, while a read of the same register returns the count as it stands now. The counter picks up the buffer contents at two moments. The first is when the timer is switched on. The second is every time the count runs past zero. Software can therefore stage a new period during the current one without disturbing it.

Counting advances on single-cycle tick pulses from one of two sources. One is derived from the main oscillator and the other from an external clock. A select input chooses which one counts. When the count passes zero, a sticky flag is set. The flag, gated by an interrupt-enable input, drives an interrupt request. Software clears the flag with a one-cycle clear strobe.

Top module: `reload_down_timer`

## Requirements
- R1: After reset, the count (reg_rdata), the buffer, flag and irq are all 0, and the timer behaves as disabled.
- R2: A cycle with reg_wr=1 stores reg_wdata in the buffer only. reg_rdata keeps showing the live count and does not change because of the write.
- R3: In the first cycle that run is 1 after being 0, the count loads the buffer value held before that cycle. A write in the same cycle and a tick in the same cycle have no effect on that load.
- R4: While run stays 1, each selected tick lowers a nonzero count by exactly 1 at the next clock edge.
- R5: src_sel=0 selects osc_tick and src_sel=1 selects ext_tick. Pulses on the unselected source change nothing.
- R6: While run is 0, the count holds its value whatever the ticks do.
- R7: A selected tick at count 0 while running is an underflow. The count takes the buffer value instead of the all-ones value, and the flag becomes 1.
- R8: A buffer write made while the timer counts leaves the current count unaffected. The new value is used at the next reload.
- R9: The flag stays 1 until flag_clr is pulsed. If an underflow and flag_clr occur in the same cycle, the flag ends up 1.
- R10: irq is 1 exactly when the flag is 1 and irq_en is 1. Toggling irq_en never changes the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Count pulse from the main oscillator |
| ext_tick | input | 1 | Count pulse from the external clock |
| src_sel | input | 1 | Tick source: 0 oscillator, 1 external |
| run | input | 1 | Timer enable; a rise reloads the count |
| irq_en | input | 1 | Interrupt enable |
| reg_wr | input | 1 | Write strobe for the buffer |
| reg_wdata | input | W | Value to store in the buffer |
| reg_rdata | output | W | Live count |
| flag_clr | input | 1 | Clears the flag |
| flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bound assertions check four rules on every cycle. A rise of run loads the buffer, a stopped timer holds its count, a running timer decrements or reloads on each tick, and the flag stays set unless cleared. Other behaviour depends on values staged earlier, so only the bench scenarios can show it. This covers a period written mid-count taking effect one reload later, a write in the enable cycle being ignored, the unselected source being ignored, and clear losing to a simultaneous underflow. The reference model compares the count, flag and irq on every clock through each of these scenarios.

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         osc_tick,
  input  logic         ext_tick,
  input  logic         src_sel,
  input  logic         run,
  input  logic         irq_en,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         flag_clr,
  output logic         flag,
  output logic         irq
);
  logic [W-1:0] cnt, buf_q;
  logic run_q, tk, load, step, uflow;

  assign tk    = src_sel ? ext_tick : osc_tick;
  assign load  = run & ~run_q;
  assign step  = run & run_q & tk;
  assign uflow = step & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      buf_q <= '0;
      flag  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (reg_wr) buf_q <= reg_wdata;
      if (load || uflow) cnt <= buf_q;
      else if (step)     cnt <= cnt - 1'b1;
      if (uflow)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assign reg_rdata = cnt;
  assign irq       = flag & irq_en;
endmodule

module reload_down_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         run_q,
  input logic         tk,
  input logic         flag_clr,
  input logic         flag,
  input logic [W-1:0] cnt,
  input logic [W-1:0] buf_q
);
  assert_load_on_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !run_q |=> cnt == $past(buf_q));
  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == $past(cnt));
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && run_q && tk && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
  assert_underflow_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run && run_q && tk && cnt == '0 |=> flag && cnt == $past(buf_q));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);
endmodule

bind reload_down_timer reload_down_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .run_q(run_q), .tk(tk),
  .flag_clr(flag_clr), .flag(flag), .cnt(cnt), .buf_q(buf_q)
);

// File: tb/reload_down_timer_tb.sv
module reload_down_timer_tb;
  logic clk = 0, rst_n = 0;
  logic osc_tick = 0, ext_tick = 0, src_sel = 0, run = 0, irq_en = 0;
  logic reg_wr = 0, flag_clr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic flag, irq;
  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  int m_cnt = 0, m_buf = 0, m_flag = 0, m_prev = 0;

  always #5 clk = ~clk;

  reload_down_timer #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_tick(ext_tick),
    .src_sel(src_sel), .run(run), .irq_en(irq_en), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_clr(flag_clr),
    .flag(flag), .irq(irq));

  always @(posedge clk) begin
    bit tk, uf;
    if (!rst_n) begin
      m_cnt = 0; m_buf = 0; m_flag = 0; m_prev = 0;
    end else begin
      tk = src_sel ? ext_tick : osc_tick;
      uf = 0;
      if (run && !m_prev) m_cnt = m_buf;
      else if (run && tk) begin
        if (m_cnt == 0) begin m_cnt = m_buf; uf = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (uf) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (reg_wr) m_buf = reg_wdata;
      m_prev = run;
    end
  end

  always @(negedge clk) begin
    int exp_irq;
    exp_irq = (m_flag && irq_en) ? 1 : 0;
    n_cmp++;
    if (reg_rdata !== 8'(m_cnt)) begin
      n_bad++; $display("FAIL %s count act %0d exp %0d", phase, reg_rdata, m_cnt);
    end
    if (flag !== 1'(m_flag)) begin
      n_bad++; $display("FAIL %s flag act %0d exp %0d", phase, flag, m_flag);
    end
    if (irq !== 1'(exp_irq)) begin
      n_bad++; $display("FAIL %s irq act %0d exp %0d", phase, irq, exp_irq);
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      osc_tick = 0; ext_tick = 0; reg_wr = 0; flag_clr = 0;
    end
  endtask

  task automatic wr(int v);
    reg_wr = 1; reg_wdata = 8'(v); cyc();
  endtask

  task automatic ticks(int n, bit ext);
    for (int i = 0; i < n; i++) begin
      if (ext) ext_tick = 1; else osc_tick = 1;
      cyc();
      cyc();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++; $display("FAIL watchdog act hung exp done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    phase = "R2"; wr(5); cyc(2); wr(9); cyc();
    phase = "R3"; run = 1; osc_tick = 1; reg_wr = 1; reg_wdata = 8'd40; cyc(); cyc(2);
    phase = "R4"; ticks(4, 0);
    phase = "R5"; src_sel = 1; ticks(3, 0); ticks(2, 1); src_sel = 0;
    phase = "R6"; run = 0; ticks(3, 0); ticks(2, 1);
    phase = "R3"; wr(3); run = 1; cyc(2);
    phase = "R7"; ticks(4, 0); ticks(2, 0);
    phase = "R8"; wr(6); ticks(2, 0); ticks(3, 0);
    phase = "R10"; irq_en = 1; cyc(2); irq_en = 0; cyc(); irq_en = 1; cyc();
    phase = "R9"; cyc(3); flag_clr = 1; cyc(2);
    ticks(6, 0);
    flag_clr = 1; cyc(2);
    wr(1); ticks(2, 0);
    phase = "R9"; osc_tick = 1; flag_clr = 1; cyc(); cyc(2);
    phase = "R10"; irq_en = 0; cyc(2);
    phase = "R1"; rst_n = 0; cyc(2); rst_n = 1; run = 0; cyc(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule